// File: doc/BRIEF.md
# Signed Decimal Add/Subtract Unit

This unit adds or subtracts two signed decimal numbers. Each operand is a row of packed 4-bit BCD digits holding its magnitude, plus a separate sign bit. A control line picks addition or subtraction. The unit returns the magnitude of the result as BCD digits, together with a sign and an overflow flag. It also raises a flag when any input nibble is not a legal BCD digit.

The datapath is a ripple of per-decade BCD adders that correct the binary digit sum back into decimal. Nine's-complement stages sit on both operands and on the result. When the two effective signs differ, the operand that is negative is complemented. The carry out of the top decade then comes back in as an end-around carry. A missing carry means the result has to be complemented again to recover its magnitude. When the effective signs match, the magnitudes are added directly and the common sign is kept. The parameter `OUT_REG` selects registered outputs (one cycle of latency) or purely combinational outputs.

Top module: `sbcd_addsub`

## Requirements
- R1: Each decade forms the binary sum of its two digits and its carry-in. A sum of 0..9 is passed unchanged with carry-out 0. A sum of 10..19 becomes the digit (sum − 10) with carry-out 1. For legal inputs every result digit is therefore 0..9.
- R2: Carries move from the units decade (bits [3:0]) upward, so that for example 0999 + 0001 gives 1000.
- R3: When the effective signs match, the result magnitude is the sum of the two magnitudes taken modulo 10^N. `r_ovf` is 1 exactly when that sum reaches 10^N, and the sign is the common sign.
- R4: A sign bit of 0 means positive and 1 means negative. `sub` = 1 computes A − B, and `sub` = 0 computes A + B.
- R5: The effective sign of B is `b_neg` XOR `sub`. Subtracting a negative B therefore gives the same result as adding the positive B.
- R6: When the effective signs differ, the result is |A − B|, carrying the sign of the larger magnitude, and `r_ovf` is 0.
- R7: A result with all digits zero and `r_ovf` = 0 is always reported with `r_neg` = 0.
- R8: The pair {`r_neg`, `r_ovf`} distinguishes four outcomes: positive, positive with overflow, negative, and negative with overflow.
- R9: `bad_digit` is 1 exactly when some nibble of `a_dig` or `b_dig` exceeds 9.
- R10: With `OUT_REG` = 1, all outputs show the result for the inputs present at the previous rising clock edge, and they are all 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset |
| a_dig | input | 4*N | Magnitude of A, BCD, units digit in bits [3:0] |
| a_neg | input | 1 | Sign of A, 1 = negative |
| b_dig | input | 4*N | Magnitude of B, BCD, units digit in bits [3:0] |
| b_neg | input | 1 | Sign of B, 1 = negative |
| sub | input | 1 | 1 = A − B, 0 = A + B |
| r_dig | output | 4*N | Magnitude of the result, BCD |
| r_neg | output | 1 | Sign of the result, 1 = negative |
| r_ovf | output | 1 | Magnitude reached 10^N; only the low N digits are shown |
| bad_digit | output | 1 | An input nibble is above 9 |

## Verification
With the default registered outputs, every result (digits, sign, overflow and the illegal-digit flag) is due at the first rising edge after the operands change. All four are captured in the same register stage. The bench drives operands on a falling edge and compares on the following falling edge, with exactly one rising edge in between. One directed case samples just after the drive and before that edge, to confirm the outputs still hold the previous result. During reset, the outputs are compared with zero.

// File: rtl/sbcd_pkg.sv
package sbcd_pkg;

    localparam int DIG_W = 4;

    // nine's complement of one decimal digit
    function automatic logic [DIG_W-1:0] nines_of(input logic [DIG_W-1:0] d);
        return 4'd9 - d;
    endfunction

    function automatic logic digit_legal(input logic [DIG_W-1:0] d);
        return d <= 4'd9;
    endfunction

endpackage

// File: rtl/sbcd_digit_add.sv
module sbcd_digit_add
    import sbcd_pkg::*;
(
    input  logic [DIG_W-1:0] x,
    input  logic [DIG_W-1:0] y,
    input  logic             ci,
    output logic [DIG_W-1:0] s,
    output logic             co
);
    logic [DIG_W:0] raw;
    logic [DIG_W:0] adj;

    always_comb begin
        raw = {1'b0, x} + {1'b0, y} + {{DIG_W{1'b0}}, ci};
        adj = raw - 5'd10;
        co  = raw >= 5'd10;
        s   = co ? adj[DIG_W-1:0] : raw[DIG_W-1:0];
    end
endmodule

// File: rtl/sbcd_nines.sv
module sbcd_nines
    import sbcd_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [DIG_W*N-1:0] d,
    input  logic               en,
    output logic [DIG_W*N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_dig
        assign q[DIG_W*i +: DIG_W] = en ? nines_of(d[DIG_W*i +: DIG_W])
                                        : d[DIG_W*i +: DIG_W];
    end
endmodule

// File: rtl/sbcd_ripple.sv
module sbcd_ripple
    import sbcd_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [DIG_W*N-1:0] x,
    input  logic [DIG_W*N-1:0] y,
    input  logic               ci,
    output logic [DIG_W*N-1:0] s,
    output logic               co
);
    logic [N:0] cy;

    assign cy[0] = ci;
    assign co    = cy[N];

    for (genvar i = 0; i < N; i++) begin : g_dec
        sbcd_digit_add u_dec (
            .x  (x[DIG_W*i +: DIG_W]),
            .y  (y[DIG_W*i +: DIG_W]),
            .ci (cy[i]),
            .s  (s[DIG_W*i +: DIG_W]),
            .co (cy[i+1])
        );
    end
endmodule

// File: rtl/sbcd_addsub.sv
module sbcd_addsub
    import sbcd_pkg::*;
#(
    parameter int N       = 4,
    parameter bit OUT_REG = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIG_W*N-1:0] a_dig,
    input  logic               a_neg,
    input  logic [DIG_W*N-1:0] b_dig,
    input  logic               b_neg,
    input  logic               sub,
    output logic [DIG_W*N-1:0] r_dig,
    output logic               r_neg,
    output logic               r_ovf,
    output logic               bad_digit
);
    localparam int W = DIG_W * N;

    typedef struct packed {
        logic [W-1:0] mag;
        logic         neg;
        logic         ovf;
        logic         bad;
    } res_t;

    res_t res_d, res_q;

    logic         b_eff, mixed, comp_a, comp_b;
    logic [W-1:0] a_op, b_op, s1, s2, mag;
    logic         c1, c2, eac, recomp;

    assign b_eff  = b_neg ^ sub;
    assign mixed  = a_neg ^ b_eff;
    assign comp_a = mixed & a_neg;
    assign comp_b = mixed & b_eff;

    sbcd_nines #(.N(N)) u_cmp_a (.d(a_dig), .en(comp_a), .q(a_op));
    sbcd_nines #(.N(N)) u_cmp_b (.d(b_dig), .en(comp_b), .q(b_op));

    // first pass: operands as conditioned
    sbcd_ripple #(.N(N)) u_pass1 (.x(a_op), .y(b_op), .ci(1'b0), .s(s1), .co(c1));

    // second pass: end-around carry, only with differing signs
    assign eac = mixed & c1;
    sbcd_ripple #(.N(N)) u_pass2 (.x(s1), .y('0), .ci(eac), .s(s2), .co(c2));

    // no end-around carry with differing signs: result is in complement form
    assign recomp = mixed & ~c1;
    sbcd_nines #(.N(N)) u_fix (.d(s2), .en(recomp), .q(mag));

    always_comb begin
        logic zero;
        logic sgn;
        res_d     = '0;
        res_d.mag = mag;
        res_d.ovf = ~mixed & c1;
        zero      = (mag == '0);
        sgn       = mixed ? ~c1 : a_neg;
        res_d.neg = sgn & ~(zero & ~res_d.ovf);
        res_d.bad = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!digit_legal(a_dig[DIG_W*i +: DIG_W])) res_d.bad = 1'b1;
            if (!digit_legal(b_dig[DIG_W*i +: DIG_W])) res_d.bad = 1'b1;
        end
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) res_q <= '0;
            else        res_q <= res_d;
        end
    end else begin : g_comb
        assign res_q = res_d;
    end

    assign r_dig     = res_q.mag;
    assign r_neg     = res_q.neg;
    assign r_ovf     = res_q.ovf;
    assign bad_digit = res_q.bad;

    // ---------------- assertions ----------------
    logic out_legal;
    always_comb begin
        out_legal = 1'b1;
        for (int i = 0; i < N; i++)
            if (!digit_legal(r_dig[DIG_W*i +: DIG_W])) out_legal = 1'b0;
    end

    p_out_bcd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_digit |-> out_legal);

    p_no_neg_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_dig == '0 && !r_ovf) |-> !r_neg);

    p_eac_no_ripple_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eac |-> !c2);

    p_equal_cancel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mixed && !res_d.bad && a_dig == b_dig) |-> (mag == '0));

endmodule

// File: tb/sbcd_addsub_bench.sv
module sbcd_addsub_bench;
    localparam int N = 4;
    localparam int W = 4 * N;
    localparam longint LIM = 10000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_dig = '0, b_dig = '0;
    logic         a_neg = 1'b0, b_neg = 1'b0, sub = 1'b0;
    logic [W-1:0] r_dig;
    logic         r_neg, r_ovf, bad_digit;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    sbcd_addsub #(.N(N), .OUT_REG(1'b1)) u_sbcd_addsub (
        .clk(clk), .rst_n(rst_n),
        .a_dig(a_dig), .a_neg(a_neg), .b_dig(b_dig), .b_neg(b_neg), .sub(sub),
        .r_dig(r_dig), .r_neg(r_neg), .r_ovf(r_ovf), .bad_digit(bad_digit)
    );

    function automatic logic [W-1:0] to_bcd(input longint v);
        logic [W-1:0] r = '0;
        longint t = v;
        for (int i = 0; i < N; i++) begin
            r[4*i +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    // expected {mag, neg, ovf} from an integer model
    function automatic logic [W+1:0] model(input longint a, input bit an,
                                           input longint b, input bit bn, input bit s);
        longint va = an ? -a : a;
        longint vb = bn ? -b : b;
        longint vr = s ? va - vb : va + vb;
        longint m  = vr < 0 ? -vr : vr;
        bit ovf    = m >= LIM;
        longint lo = m % LIM;
        bit neg    = (vr < 0) && !(lo == 0 && !ovf);
        return {to_bcd(lo), neg, ovf};
    endfunction

    task automatic check(input string req, input logic [W+1:0] exp_v, input bit exp_bad);
        checks++;
        if ({r_dig, r_neg, r_ovf} !== exp_v || bad_digit !== exp_bad) begin
            fails++;
            $display("FAIL %s: got dig=%h neg=%b ovf=%b bad=%b, expected dig=%h neg=%b ovf=%b bad=%b",
                     req, r_dig, r_neg, r_ovf, bad_digit,
                     exp_v[W+1:2], exp_v[1], exp_v[0], exp_bad);
        end
    endtask

    task automatic run(input string req, input longint a, input bit an,
                       input longint b, input bit bn, input bit s);
        @(negedge clk);
        a_dig = to_bcd(a); a_neg = an; b_dig = to_bcd(b); b_neg = bn; sub = s;
        @(negedge clk);
        check(req, model(a, an, b, bn, s), 1'b0);
    endtask

    task automatic finish_up;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got hang, expected completion");
            finish_up();
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        a_dig = to_bcd(77); b_dig = to_bcd(12);
        repeat (3) @(negedge clk);
        check("R10 reset", '0, 1'b0);
        rst_n = 1'b1;

        run("R1 digit correction", 5, 0, 7, 0, 0);
        run("R2 carry ripple", 999, 0, 1, 0, 0);
        run("R3 overflow positive", 9999, 0, 1, 0, 0);
        run("R8 negative with overflow", 9999, 1, 1, 0, 1);
        run("R5 subtract negative", 5, 0, 3, 1, 1);
        run("R4 subtract smaller minus larger", 3, 0, 8, 0, 1);
        run("R6 mixed signs", 8, 1, 3, 0, 0);
        run("R6 mixed large", 1200, 0, 4567, 1, 0);
        run("R7 equal cancel", 1234, 0, 1234, 0, 1);
        run("R7 negative zeros", 0, 1, 0, 0, 1);
        run("R3 both negative", 4000, 1, 2500, 1, 0);
        run("R8 positive exact overflow", 5000, 0, 5000, 1, 1);

        // R10: before the edge the previous result must still be shown
        @(negedge clk);
        a_dig = to_bcd(1); a_neg = 0; b_dig = to_bcd(1); b_neg = 0; sub = 0;
        #1;
        check("R10 latency hold", model(5000, 0, 5000, 1, 1), 1'b0);
        @(negedge clk);
        check("R10 latency update", model(1, 0, 1, 0, 0), 1'b0);

        // R9: illegal nibble flagged
        @(negedge clk);
        a_dig = 16'h00A0; b_dig = to_bcd(3); a_neg = 0; b_neg = 0; sub = 0;
        @(negedge clk);
        checks++;
        if (bad_digit !== 1'b1) begin
            fails++;
            $display("FAIL R9 bad nibble: got %b, expected 1", bad_digit);
        end
        run("R9 legal clears flag", 12, 0, 34, 0, 0);

        for (int k = 0; k < 400; k++) begin
            longint a = longint'($urandom % 10000);
            longint b = ($urandom % 4 == 0) ? a : longint'($urandom % 10000);
            bit an = 1'($urandom), bn = 1'($urandom), s = 1'($urandom);
            run((an ^ bn ^ s) ? "R6 random" : "R3 random", a, an, b, bn, s);
        end

        done = 1;
        finish_up();
    end
endmodule